// File: doc/BRIEF.md
# Delayed-Read Lead-Off Wait-State Controller

This block is the target-side policy engine of a bridge that serves upstream memory reads as delayed transactions. It holds one request slot. When a read is queued internally, a latency counter starts. The master later comes back for the data by asserting FRAME#. At that point the controller chooses one of three responses: hand over the data (TRDY#), hold the bus with wait states, or signal retry (STOP#). The choice depends on whether completion data is present and on whether the time since queuing has reached a programmable threshold.

A 32-bit policy register holds the threshold and a discard test-mode bit. A completion that has arrived but is never collected is dropped by a discard timer. The timer's limit comes either from the test-mode bit or from a bridge-control select input. The full bus protocol and the data path are outside this block.

The slot machine has three states. Its transitions are:
- SLOT_EMPTY to SLOT_PEND when a request is queued.
- SLOT_PEND to SLOT_READY when the completion arrives.
- SLOT_PEND or SLOT_READY back to SLOT_EMPTY when the data is taken.
- SLOT_READY to SLOT_EMPTY when the discard timer expires.

The bus machine has five states. Its transitions are:
- B_IDLE to B_XFER when data is available.
- B_IDLE to B_WAIT when the request is late and data is missing.
- B_IDLE to B_RETRY when the request is early, the slot is empty, or the policy is disabled.
- B_WAIT to B_XFER when data arrives.
- B_WAIT to B_RETRY at the lead-off limit.
- B_XFER and B_RETRY to B_TURN.
- B_TURN to B_IDLE once FRAME# is released.

Top module: `rdlat_wait_ctrl`

## Requirements
- R1: After reset the policy register reads 0x00001200. This means threshold 18 in bits 13:8 and test bit 5 clear. TRDY# and STOP# are high, no discard pulse is present and the slot is free.
- R2: Only bits 13:8 (threshold) and bit 5 (discard test mode) of the policy register are writable. Every other bit reads zero after any write.
- R3: If data is available when FRAME# is sampled low in B_IDLE, TRDY# goes low on the next clock with STOP# high, and the slot is freed. Data is available if it was received earlier or is flagged in that same cycle. TRDY# and STOP# are never low together.
- R4: If FRAME# is sampled low while the latency count is below a nonzero threshold and data is absent, STOP# goes low on the next clock and TRDY# stays high. The latency count equals the number of clock edges since the queuing edge, counting that edge as 1.
- R5: If FRAME# is sampled low with latency count ≥ a nonzero threshold (equality included) and data is absent, both outputs stay high for wait clocks 1 through 15. If data is still absent, STOP# goes low on clock 16 after the FRAME# sample.
- R6: If the completion flag is seen during a wait clock, TRDY# goes low on the next clock without a retry, and the slot is freed.
- R7: If data arrives on wait clock 15, TRDY# is asserted on clock 16 instead of STOP#.
- R8: With threshold zero, wait states are never inserted. A missing completion always causes STOP# on the next clock, however late the return.
- R9: With test bit 5 set, an uncollected completion is discarded 128 clocks after the edge that captured it. The discard pulse lasts one clock and the slot becomes free in that same clock.
- R10: With test bit 5 clear, the discard limit is 1024 clocks when the select input is low and 32768 clocks when it is high.
- R11: If the master collects the data on the same edge at which the discard timer would expire, the collection wins. TRDY# asserts and no discard pulse is raised.
- R12: A queue request while the slot is occupied is ignored and does not restart the latency count. A completion flag while the slot is empty is ignored.
- R13: If FRAME# is sampled low with no queued request, STOP# goes low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Policy register write strobe |
| cfg_wdata | input | 32 | Policy register write data |
| cfg_rdata | output | 32 | Policy register contents |
| disc_long_sel | input | 1 | Bridge-control discard select: 0 gives the short limit, 1 the long limit |
| rd_queued | input | 1 | Upstream memory read queued internally (one clock) |
| cpl_ready | input | 1 | Completion data for the queued read is present |
| frame_n | input | 1 | FRAME# from the returning master, active low |
| trdy_n | output | 1 | TRDY# response, active low |
| stop_n | output | 1 | STOP# (retry) response, active low |
| slot_busy | output | 1 | Request slot occupied |
| discard_pulse | output | 1 | One-clock pulse when an uncollected completion is dropped |

## Verification
Two pairs of functions can act on the same clock edge.

The first pair is completion arrival and the lead-off limit. The bench drives the completion flag exactly on wait clock 15. The result passes only if TRDY#, not STOP#, appears on clock 16.

The second pair is master collection and discard expiry. The bench lowers FRAME# in the 128th clock of a test-mode discard window. That case passes only if TRDY# asserts, the discard pulse stays low and the slot is freed.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

    typedef enum logic [2:0] {
        B_IDLE,
        B_WAIT,
        B_XFER,
        B_RETRY,
        B_TURN
    } bus_st_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_PEND,
        SLOT_READY
    } slot_st_t;

endpackage

// File: rtl/rdlat_cfg_reg.sv
module rdlat_cfg_reg #(
    parameter int          THR_LSB  = 8,
    parameter int          THR_W    = 6,
    parameter int          TEST_BIT = 5,
    parameter logic [31:0] RST_VAL  = 32'h0000_1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic [THR_W-1:0] thr,
    output logic             test_mode
);
    localparam logic [31:0] THR_MASK = ((32'd1 << THR_W) - 32'd1) << THR_LSB;
    localparam logic [31:0] WR_MASK  = THR_MASK | (32'd1 << TEST_BIT);

    logic [31:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RST_VAL & WR_MASK;
        end else if (we) begin
            reg_q <= wdata & WR_MASK;
        end
    end

    always_comb begin
        rdata     = reg_q;
        thr       = reg_q[THR_LSB +: THR_W];
        test_mode = reg_q[TEST_BIT];
    end
endmodule

// File: rtl/rdlat_lat_timer.sv
module rdlat_lat_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(1);
        end else if (run && cnt != SAT) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rdlat_disc_timer.sv
module rdlat_disc_timer #(
    parameter int TEST_CLKS  = 128,
    parameter int SHORT_CLKS = 1024,
    parameter int LONG_CLKS  = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic test_mode,
    input  logic sel_long,
    output logic expire
);
    localparam int MAX_A = (TEST_CLKS > SHORT_CLKS) ? TEST_CLKS : SHORT_CLKS;
    localparam int MAX_L = (MAX_A > LONG_CLKS) ? MAX_A : LONG_CLKS;
    localparam int CW    = $clog2(MAX_L + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        if (test_mode) begin
            last = CW'(TEST_CLKS - 1);
        end else if (sel_long) begin
            last = CW'(LONG_CLKS - 1);
        end else begin
            last = CW'(SHORT_CLKS - 1);
        end
        expire = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rdlat_bus_fsm.sv
module rdlat_bus_fsm
    import rdlat_pkg::*;
#(
    parameter int LEAD_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic have_slot,
    input  logic data_now,
    input  logic late,
    output logic take,
    output logic trdy_n,
    output logic stop_n
);
    localparam int            WW     = $clog2(LEAD_MAX + 1);
    localparam logic [WW-1:0] W_LAST = WW'(LEAD_MAX - 1);

    bus_st_t       st, st_nx;
    logic [WW-1:0] wcnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= B_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // lead-off clock counter: 1 on the first wait clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= WW'(1);
        end else if (st == B_WAIT) begin
            wcnt <= wcnt + WW'(1);
        end else begin
            wcnt <= WW'(1);
        end
    end

    always_comb begin
        st_nx = st;
        take  = 1'b0;
        unique case (st)
            B_IDLE: begin
                if (!frame_n) begin
                    if (have_slot && data_now) begin
                        st_nx = B_XFER;
                        take  = 1'b1;
                    end else if (have_slot && late) begin
                        st_nx = B_WAIT;
                    end else begin
                        st_nx = B_RETRY;
                    end
                end
            end
            B_WAIT: begin
                if (data_now) begin
                    st_nx = B_XFER;
                    take  = 1'b1;
                end else if (wcnt == W_LAST) begin
                    st_nx = B_RETRY;
                end
            end
            B_XFER:  st_nx = B_TURN;
            B_RETRY: st_nx = B_TURN;
            B_TURN: begin
                if (frame_n) begin
                    st_nx = B_IDLE;
                end
            end
            default: st_nx = B_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trdy_n = (st != B_XFER);
        stop_n = (st != B_RETRY);
    end
endmodule

// File: rtl/rdlat_wait_ctrl.sv
module rdlat_wait_ctrl
    import rdlat_pkg::*;
#(
    parameter int          THR_LSB    = 8,
    parameter int          THR_W      = 6,
    parameter int          TEST_BIT   = 5,
    parameter logic [31:0] RST_VAL    = 32'h0000_1200,
    parameter int          LEAD_MAX   = 16,
    parameter int          DISC_TEST  = 128,
    parameter int          DISC_SHORT = 1024,
    parameter int          DISC_LONG  = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        disc_long_sel,
    input  logic        rd_queued,
    input  logic        cpl_ready,
    input  logic        frame_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        slot_busy,
    output logic        discard_pulse
);
    logic [THR_W-1:0] thr;
    logic             test_mode;
    logic [THR_W-1:0] lat;
    logic             accept;
    logic             data_now;
    logic             late;
    logic             take;
    logic             expire;
    slot_st_t         slot, slot_nx;

    rdlat_cfg_reg #(
        .THR_LSB (THR_LSB),
        .THR_W   (THR_W),
        .TEST_BIT(TEST_BIT),
        .RST_VAL (RST_VAL)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .thr      (thr),
        .test_mode(test_mode)
    );

    rdlat_lat_timer #(.W(THR_W)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .run  (slot == SLOT_PEND),
        .cnt  (lat)
    );

    rdlat_disc_timer #(
        .TEST_CLKS (DISC_TEST),
        .SHORT_CLKS(DISC_SHORT),
        .LONG_CLKS (DISC_LONG)
    ) u_disc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (slot == SLOT_READY),
        .test_mode(test_mode),
        .sel_long (disc_long_sel),
        .expire   (expire)
    );

    always_comb begin
        accept   = (slot == SLOT_EMPTY) && rd_queued;
        data_now = (slot == SLOT_READY) || ((slot == SLOT_PEND) && cpl_ready);
        late     = (thr != '0) && (lat >= thr);
    end

    rdlat_bus_fsm #(.LEAD_MAX(LEAD_MAX)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .have_slot(slot != SLOT_EMPTY),
        .data_now (data_now),
        .late     (late),
        .take     (take),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n)
    );

    // slot state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= SLOT_EMPTY;
        end else begin
            slot <= slot_nx;
        end
    end

    always_comb begin
        slot_nx = slot;
        unique case (slot)
            SLOT_EMPTY: if (accept) slot_nx = SLOT_PEND;
            SLOT_PEND: begin
                if (take) begin
                    slot_nx = SLOT_EMPTY;
                end else if (cpl_ready) begin
                    slot_nx = SLOT_READY;
                end
            end
            SLOT_READY: begin
                if (take || expire) begin
                    slot_nx = SLOT_EMPTY;
                end
            end
            default: slot_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            discard_pulse <= 1'b0;
        end else begin
            discard_pulse <= (slot == SLOT_READY) && expire && !take;
        end
    end

    // outputs
    always_comb begin
        slot_busy = (slot != SLOT_EMPTY);
    end
endmodule

// File: rtl/rdlat_wait_chk.sv
module rdlat_wait_chk #(
    parameter int LEAD_MAX = 16,
    parameter int THR_LSB  = 8,
    parameter int THR_W    = 6,
    parameter int TEST_BIT = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        slot_busy,
    input logic        discard_pulse,
    input logic [31:0] cfg_rdata
);
    localparam logic [31:0] MASK = (((32'd1 << THR_W) - 32'd1) << THR_LSB) | (32'd1 << TEST_BIT);
    localparam int          LW   = $clog2(LEAD_MAX + 1) + 1;

    logic          frame_q;
    logic          armed;
    logic [LW-1:0] lcnt;
    logic          thr_zero;

    assign thr_zero = (cfg_rdata[THR_LSB +: THR_W] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            armed   <= 1'b0;
            lcnt    <= '0;
        end else begin
            frame_q <= frame_n;
            if (!frame_n && frame_q && trdy_n && stop_n) begin
                armed <= 1'b1;
                lcnt  <= LW'(1);
            end else if (armed && (!trdy_n || !stop_n)) begin
                armed <= 1'b0;
            end else if (armed) begin
                lcnt <= lcnt + LW'(1);
            end
        end
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~MASK) == 32'd0);

    assert_no_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_n && !stop_n));

    assert_leadoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && trdy_n && stop_n) |-> (lcnt < LW'(LEAD_MAX)));

    assert_nowait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && thr_zero && trdy_n && stop_n) |=> (!trdy_n || !stop_n));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        discard_pulse |=> !discard_pulse);

    assert_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        discard_pulse |-> (!slot_busy && $past(slot_busy)));
endmodule

bind rdlat_wait_ctrl rdlat_wait_chk #(
    .LEAD_MAX(LEAD_MAX),
    .THR_LSB (THR_LSB),
    .THR_W   (THR_W),
    .TEST_BIT(TEST_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .trdy_n       (trdy_n),
    .stop_n       (stop_n),
    .slot_busy    (slot_busy),
    .discard_pulse(discard_pulse),
    .cfg_rdata    (cfg_rdata)
);

// File: tb/sim_rdlat_wait_ctrl.sv
`timescale 1ns/1ps
module sim_rdlat_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        disc_long_sel = 1'b0;
    logic        rd_queued = 1'b0;
    logic        cpl_ready = 1'b0;
    logic        frame_n = 1'b1;
    logic        trdy_n, stop_n, slot_busy, discard_pulse;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rdlat_wait_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .disc_long_sel(disc_long_sel),
        .rd_queued    (rd_queued),
        .cpl_ready    (cpl_ready),
        .frame_n      (frame_n),
        .trdy_n       (trdy_n),
        .stop_n       (stop_n),
        .slot_busy    (slot_busy),
        .discard_pulse(discard_pulse)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_n = 1'b1; rd_queued = 1'b0; cpl_ready = 1'b0;
        cfg_we = 1'b0; disc_long_sel = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_cfg(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    // queue a read and let the latency count reach 'age'
    task automatic queue_age(input int age);
        rd_queued = 1'b1;
        tick();
        rd_queued = 1'b0;
        repeat (age - 1) tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cfg", cfg_rdata, 32'h0000_1200);
        chk("R1 outs", {28'd0, trdy_n, stop_n, slot_busy, discard_pulse}, 32'hC);
    endtask

    task automatic t_reserved();
        do_reset();
        set_cfg(32'hFFFF_FFFF);
        chk("R2 all ones", cfg_rdata, 32'h0000_3F20);
        set_cfg(32'h0000_C0DF);
        chk("R2 pattern", cfg_rdata, 32'h0000_0000);
    endtask

    task automatic t_early();
        do_reset();
        queue_age(5);
        frame_n = 1'b0; tick();
        chk("R4 early retry", {30'd0, trdy_n, stop_n}, 32'h2);
        do_reset();
        queue_age(17);
        frame_n = 1'b0; tick();
        chk("R4 one below thr", {30'd0, trdy_n, stop_n}, 32'h2);
    endtask

    task automatic t_wait_full(input int age, input string tag);
        bit ok = 1;
        do_reset();
        queue_age(age);
        frame_n = 1'b0; tick();
        for (int k = 1; k <= 15; k++) begin
            if (k > 1) tick();
            if (!(trdy_n && stop_n)) ok = 0;
        end
        chk({tag, " wait 1..15"}, {31'd0, ok}, 32'd1);
        tick();
        chk({tag, " retry at 16"}, {30'd0, trdy_n, stop_n}, 32'h2);
    endtask

    task automatic t_data_in_wait(input int at_k, input string tag);
        do_reset();
        queue_age(20);
        frame_n = 1'b0; tick();
        for (int k = 2; k <= at_k; k++) tick();
        chk({tag, " still waiting"}, {30'd0, trdy_n, stop_n}, 32'h3);
        cpl_ready = 1'b1; tick(); cpl_ready = 1'b0;
        chk({tag, " trdy"}, {29'd0, trdy_n, stop_n, slot_busy}, 32'h1 << 1);
    endtask

    task automatic t_data_ready();
        do_reset();
        queue_age(3);
        cpl_ready = 1'b1; tick(); cpl_ready = 1'b0;
        frame_n = 1'b0; tick();
        chk("R3 collected", {29'd0, trdy_n, stop_n, slot_busy}, 32'h2);
        do_reset();
        queue_age(3);
        cpl_ready = 1'b1; frame_n = 1'b0; tick(); cpl_ready = 1'b0;
        chk("R3 same cycle", {29'd0, trdy_n, stop_n, slot_busy}, 32'h2);
    endtask

    task automatic t_thr_zero();
        do_reset();
        set_cfg(32'h0);
        queue_age(40);
        frame_n = 1'b0; tick();
        chk("R8 no wait", {30'd0, trdy_n, stop_n}, 32'h2);
    endtask

    task automatic t_discard(input logic [31:0] cfg, input logic sel, input int lim, input string tag);
        bit ok = 1;
        do_reset();
        set_cfg(cfg);
        disc_long_sel = sel;
        queue_age(2);
        cpl_ready = 1'b1; tick(); cpl_ready = 1'b0;
        for (int j = 1; j < lim; j++) begin
            tick();
            if (discard_pulse || !slot_busy) ok = 0;
        end
        chk({tag, " hold"}, {31'd0, ok}, 32'd1);
        tick();
        chk({tag, " expire"}, {30'd0, discard_pulse, slot_busy}, 32'h2);
        tick();
        chk({tag, " one clock"}, {31'd0, discard_pulse}, 32'd0);
    endtask

    task automatic t_collect_vs_expire();
        do_reset();
        set_cfg(32'h0000_1220);
        queue_age(2);
        cpl_ready = 1'b1; tick(); cpl_ready = 1'b0;
        repeat (127) tick();
        frame_n = 1'b0; tick();
        chk("R11 collect wins", {28'd0, trdy_n, stop_n, slot_busy, discard_pulse}, 32'h4);
        frame_n = 1'b1; tick();
        chk("R11 no late pulse", {31'd0, discard_pulse}, 32'd0);
    endtask

    task automatic t_ignored();
        do_reset();
        cpl_ready = 1'b1; tick(); cpl_ready = 1'b0;
        chk("R12 stray completion", {31'd0, slot_busy}, 32'd0);
        queue_age(10);
        rd_queued = 1'b1; tick(); rd_queued = 1'b0;
        repeat (9) tick();
        frame_n = 1'b0; tick();
        chk("R12 no restart", {30'd0, trdy_n, stop_n}, 32'h3);
    endtask

    task automatic t_no_req();
        do_reset();
        frame_n = 1'b0; tick();
        chk("R13 empty retry", {30'd0, trdy_n, stop_n}, 32'h2);
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_early();
        t_wait_full(20, "R5 late");
        t_wait_full(18, "R5 at thr");
        t_data_in_wait(5, "R6");
        t_data_in_wait(15, "R7");
        t_data_ready();
        t_thr_zero();
        t_discard(32'h0000_1220, 1'b0, 128, "R9");
        t_discard(32'h0000_1200, 1'b0, 1024, "R10 short");
        t_discard(32'h0000_1200, 1'b1, 32768, "R10 long");
        t_collect_vs_expire();
        t_ignored();
        t_no_req();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule